// File: doc/BRIEF.md
# Ethernet multicast hash address filter

This block sits on the receive side of an Ethernet MAC and decides, frame by frame, whether to keep a frame based only on its 48-bit destination address. The address arrives one byte per clock, first wire byte first. While the bytes stream in, a CRC-32 runs over them. The most significant bits of the finished, complemented and bit-reversed CRC index a hash table that software programs. The upper index bits pick a 32-bit table word and the low five bits pick a bit inside that word.

The table depth is fixed when the block is built: 64, 128 or 256 bins, chosen by the `HASH_BINS` parameter. The depth sets how many CRC bits form the index and how many table words exist. A read-only feature field reports the chosen depth to software. Software also reaches a filter-mode register and a station address compare register. The verdict comes out as an accept bit together with a one-cycle valid strobe.

Top module: `mc_hash_filter`

## Requirements
- R1: The mode register at offset 0x08 holds six mode bits and reads back exactly those bits, with all other bits reading 0. The bits are: bit0 promiscuous, bit1 pass all multicast, bit2 hash multicast, bit3 unicast hash-or-station, bit4 pass pause frames, bit5 broadcast off. The register resets to 0.
- R2: Offset 0x40 is read-only. Its bits 25:24 hold k, where the table has 32·2^k bins (1 for 64, 2 for 128, 3 for 256), and every other bit reads 0.
- R3: Hash table word i lives at offset 0x10+4·i for i below HASH_BINS/32 and resets to 0. Writes to words at or beyond that count (up to offset 0x2C) are ignored, and those words read 0.
- R4: rx_valid pulses high for exactly one cycle, in the cycle after the clock edge that takes the sixth address byte. rx_accept is 0 whenever rx_valid is 0.
- R5: With promiscuous set, every address is accepted.
- R6: The broadcast address FF:FF:FF:FF:FF:FF is accepted unless broadcast off is set, in which case it is dropped. Promiscuous mode overrides broadcast off.
- R7: Outside promiscuous mode, a multicast address (bit 0 of the first byte is 1) that is neither broadcast nor the pause address is accepted when pass all multicast is set.
- R8: With hash multicast set and pass all multicast clear, such a multicast address is accepted only if table bit idx[4:0] of word idx>>5 is 1. Here idx is the top log2(HASH_BINS) bits of the bit-reversed complement of the reflected CRC-32 (polynomial 0xEDB88320, initial value all ones) over the six bytes. A table of all ones therefore accepts every multicast address.
- R9: A unicast address (bit 0 of the first byte is 0) is accepted when it equals the station address. Offset 0x44 holds bytes 0..3 (byte 0 in bits 7:0), and offset 0x48 bits 15:0 hold bytes 4..5. Any other unicast address is dropped unless R10 applies.
- R10: With unicast hash-or-station set, a unicast address is also accepted when its indexed table bit (computed as in R8) is 1.
- R11: The pause address 01:80:C2:00:00:01 is accepted only when pass pause frames is set (or in promiscuous mode). The multicast modes do not apply to it.
- R12: Asserting da_first with a byte restarts collection at byte 0, abandoning any partial address. Bytes that arrive while idle without da_first are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| da_valid | input | 1 | Address byte valid |
| da_first | input | 1 | Marks the first address byte |
| da_byte | input | 8 | Address byte, wire order |
| rx_valid | output | 1 | Verdict strobe |
| rx_accept | output | 1 | 1 keeps the frame, 0 drops it |

## Verification
On every cycle, the assertions check the single-cycle shape of the verdict strobe and that accept stays low between verdicts. They also check the constant content of the feature field, and that promiscuous mode, plain multicast under pass-all, and broadcast with broadcast enabled always lead to an accept. Only the bench's scenarios can show that the CRC index lands on the right table word and bit, and that station matching and the hash fallback for unicast work. The same holds for the pause-frame rule, for ignored writes beyond the configured depth, and for restarting on a new first byte. Each of these depends on specific address values and programmed table contents.

// File: rtl/mhf_pkg.sv
package mhf_pkg;

   localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;
   localparam int          ADDR_BYTES    = 6;
   localparam int          WORD_BITS     = 32;
   localparam int          MAX_WORDS     = 8;

   localparam logic [7:0]  OFS_MODE      = 8'h08;
   localparam logic [7:0]  OFS_TBL_BASE  = 8'h10;
   localparam logic [7:0]  OFS_TBL_END   = 8'h30;
   localparam logic [7:0]  OFS_FEAT      = 8'h40;
   localparam logic [7:0]  OFS_STA_LO    = 8'h44;
   localparam logic [7:0]  OFS_STA_HI    = 8'h48;

   localparam logic [47:0] PAUSE_DA      = 48'h0100_00C2_8001;

   typedef struct packed {
      logic bcast_off;
      logic ctl_pass;
      logic uc_hash;
      logic mc_hash;
      logic mc_all;
      logic promisc;
   } mode_t;

   function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
      logic [31:0] r;
      r = c ^ {24'h0, d};
      for (int i = 0; i < 8; i++)
         r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
      return r;
   endfunction

endpackage

// File: rtl/mhf_addr_collect.sv
module mhf_addr_collect
   import mhf_pkg::*;
#(
   parameter int IDX_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             da_valid,
   input  logic             da_first,
   input  logic [7:0]       da_byte,
   output logic             done,
   output logic [47:0]      addr,
   output logic [IDX_W-1:0] idx
);

   localparam int CNT_W = $clog2(ADDR_BYTES);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(ADDR_BYTES - 1);

   logic [CNT_W-1:0]              cnt_q;
   logic [ADDR_BYTES-2:0][7:0]    bytes_q;
   logic [31:0]                   crc_q;
   logic [31:0]                   crc_nx;

   always_comb begin
      crc_nx = crc_byte(da_first ? 32'hFFFF_FFFF : crc_q, da_byte);
      done   = da_valid && !da_first && (cnt_q == LAST);
      addr   = {da_byte, bytes_q};
      for (int j = 0; j < IDX_W; j++)
         idx[IDX_W-1-j] = ~crc_nx[j];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         crc_q <= '1;
      end else if (da_valid) begin
         if (da_first) begin
            cnt_q <= CNT_W'(1);
            crc_q <= crc_nx;
         end else if (cnt_q != '0) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CNT_W'(1);
            crc_q <= crc_nx;
         end
      end
   end

   for (genvar g = 0; g < ADDR_BYTES - 1; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            bytes_q[g] <= '0;
         else if (da_valid && ((g == 0 && da_first) ||
                               (!da_first && cnt_q == CNT_W'(g) && cnt_q != '0)))
            bytes_q[g] <= da_byte;
      end
   end

endmodule

// File: rtl/mhf_hash_table.sv
module mhf_hash_table
   import mhf_pkg::*;
#(
   parameter int HASH_BINS = 128
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [$clog2(MAX_WORDS)-1:0]   wr_word,
   input  logic [31:0]                    wdata,
   input  logic [$clog2(MAX_WORDS)-1:0]   rd_word,
   output logic [31:0]                    rd_data,
   input  logic [$clog2(HASH_BINS)-1:0]   idx,
   output logic                           hit
);

   localparam int WORDS = HASH_BINS / WORD_BITS;
   localparam int IDX_W = $clog2(HASH_BINS);
   localparam int SEL_W = IDX_W - 5;

   logic [WORDS-1:0][31:0] tbl_q;

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            tbl_q[w] <= '0;
         else if (wr_en && int'(wr_word) == w)
            tbl_q[w] <= wdata;
      end
   end

   always_comb begin
      rd_data = (int'(rd_word) < WORDS) ? tbl_q[rd_word[SEL_W-1:0]] : '0;
      hit     = tbl_q[idx[IDX_W-1:5]][idx[4:0]];
   end

endmodule

// File: rtl/mhf_decide.sv
module mhf_decide
   import mhf_pkg::*;
(
   input  mode_t        mode,
   input  logic [47:0]  addr,
   input  logic [47:0]  station,
   input  logic         hit,
   output logic         accept
);

   always_comb begin
      if (mode.promisc)
         accept = 1'b1;
      else if (addr == '1)
         accept = !mode.bcast_off;
      else if (addr == PAUSE_DA)
         accept = mode.ctl_pass;
      else if (addr[0])
         accept = mode.mc_all || (mode.mc_hash && hit);
      else
         accept = (addr == station) || (mode.uc_hash && hit);
   end

endmodule

// File: rtl/mc_hash_filter.sv
module mc_hash_filter
   import mhf_pkg::*;
#(
   parameter int HASH_BINS = 128
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic [7:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   input  logic        da_valid,
   input  logic        da_first,
   input  logic [7:0]  da_byte,
   output logic        rx_valid,
   output logic        rx_accept
);

   localparam int         IDX_W     = $clog2(HASH_BINS);
   localparam int         WSEL_W    = $clog2(MAX_WORDS);
   localparam logic [1:0] FEAT_CODE = 2'($clog2(HASH_BINS / WORD_BITS));

   if (HASH_BINS != 64 && HASH_BINS != 128 && HASH_BINS != 256) begin : g_bad_bins
      $error("HASH_BINS must be 64, 128 or 256");
   end

   mode_t              mode_q;
   logic [31:0]        sta_lo_q;
   logic [15:0]        sta_hi_q;
   logic               tbl_sel;
   logic [7:0]         tbl_off;
   logic [WSEL_W-1:0]  tbl_word;
   logic [31:0]        tbl_rd;
   logic               tbl_hit;
   logic               col_done;
   logic [47:0]        col_addr;
   logic [IDX_W-1:0]   col_idx;
   logic               verdict;

   always_comb begin
      tbl_sel  = (reg_addr >= OFS_TBL_BASE) && (reg_addr < OFS_TBL_END) && (reg_addr[1:0] == 2'b00);
      tbl_off  = reg_addr - OFS_TBL_BASE;
      tbl_word = tbl_off[WSEL_W+1:2];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= '0;
         sta_lo_q <= '0;
         sta_hi_q <= '0;
      end else if (reg_wr) begin
         if (reg_addr == OFS_MODE)   mode_q   <= mode_t'(reg_wdata[$bits(mode_t)-1:0]);
         if (reg_addr == OFS_STA_LO) sta_lo_q <= reg_wdata;
         if (reg_addr == OFS_STA_HI) sta_hi_q <= reg_wdata[15:0];
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == OFS_MODE)        reg_rdata[$bits(mode_t)-1:0] = mode_q;
      else if (tbl_sel)                reg_rdata = tbl_rd;
      else if (reg_addr == OFS_FEAT)   reg_rdata[25:24] = FEAT_CODE;
      else if (reg_addr == OFS_STA_LO) reg_rdata = sta_lo_q;
      else if (reg_addr == OFS_STA_HI) reg_rdata[15:0] = sta_hi_q;
   end

   mhf_addr_collect #(.IDX_W(IDX_W)) u_col (
      .clk      (clk),
      .rst_n    (rst_n),
      .da_valid (da_valid),
      .da_first (da_first),
      .da_byte  (da_byte),
      .done     (col_done),
      .addr     (col_addr),
      .idx      (col_idx)
   );

   mhf_hash_table #(.HASH_BINS(HASH_BINS)) u_tbl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_wr && tbl_sel),
      .wr_word (tbl_word),
      .wdata   (reg_wdata),
      .rd_word (tbl_word),
      .rd_data (tbl_rd),
      .idx     (col_idx),
      .hit     (tbl_hit)
   );

   mhf_decide u_dec (
      .mode    (mode_q),
      .addr    (col_addr),
      .station ({sta_hi_q, sta_lo_q}),
      .hit     (tbl_hit),
      .accept  (verdict)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_valid  <= 1'b0;
         rx_accept <= 1'b0;
      end else begin
         rx_valid  <= col_done;
         rx_accept <= col_done && verdict;
      end
   end

endmodule

// File: rtl/mhf_checker.sv
module mhf_checker
   import mhf_pkg::*;
#(
   parameter int HASH_BINS = 128
) (
   input logic        clk,
   input logic        rst_n,
   input logic        rx_valid,
   input logic        rx_accept,
   input logic [7:0]  reg_addr,
   input logic [31:0] reg_rdata,
   input mode_t       mode_q,
   input logic        col_done,
   input logic [47:0] col_addr
);

   localparam logic [1:0] EXP_CODE = 2'($clog2(HASH_BINS / WORD_BITS));

   p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   p_accept_needs_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |-> !rx_accept);

   p_feature_field_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == OFS_FEAT) |-> (reg_rdata == {6'b0, EXP_CODE, 24'b0}));

   p_promisc_accepts_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && $past(mode_q.promisc)) |-> rx_accept);

   p_bcast_accepts_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && $past(col_addr == '1 && !mode_q.bcast_off)) |-> rx_accept);

   p_pass_all_mc_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && $past(mode_q.mc_all && col_addr[0] && col_addr != '1 &&
                         col_addr != PAUSE_DA)) |-> rx_accept);

endmodule

bind mc_hash_filter mhf_checker #(.HASH_BINS(HASH_BINS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rx_valid  (rx_valid),
   .rx_accept (rx_accept),
   .reg_addr  (reg_addr),
   .reg_rdata (reg_rdata),
   .mode_q    (mode_q),
   .col_done  (col_done),
   .col_addr  (col_addr)
);

// File: tb/mc_hash_filter_tb.sv
`timescale 1ns/1ps
module mc_hash_filter_tb;

   localparam int BINS  = 128;
   localparam int IDXW  = $clog2(BINS);
   localparam int WORDS = BINS / 32;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        reg_wr = 0;
   logic [7:0]  reg_addr = 0;
   logic [31:0] reg_wdata = 0;
   logic [31:0] reg_rdata;
   logic        da_valid = 0;
   logic        da_first = 0;
   logic [7:0]  da_byte = 0;
   logic        rx_valid;
   logic        rx_accept;

   int checks = 0;
   int fails  = 0;

   logic [5:0]  m_mode = 0;
   logic [31:0] m_tbl [WORDS];
   logic [47:0] m_sta = 0;

   logic  exp_acc [$];
   string exp_tag [$];

   always #4 clk = ~clk;

   mc_hash_filter #(.HASH_BINS(BINS)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .da_valid(da_valid),
      .da_first(da_first), .da_byte(da_byte), .rx_valid(rx_valid),
      .rx_accept(rx_accept));

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [IDXW-1:0] hidx(input logic [47:0] a);
      logic [31:0] c = 32'hFFFF_FFFF;
      logic fb;
      logic [IDXW-1:0] r;
      for (int i = 0; i < 48; i++) begin
         fb = c[0] ^ a[i];
         c  = {1'b0, c[31:1]};
         if (fb) c = c ^ 32'hEDB8_8320;
      end
      c = ~c;
      for (int j = 0; j < IDXW; j++) r[IDXW-1-j] = c[j];
      return r;
   endfunction

   function automatic logic model(input logic [47:0] a);
      logic [IDXW-1:0] ix = hidx(a);
      logic hit = m_tbl[ix >> 5][ix[4:0]];
      if (m_mode[0]) return 1'b1;
      if (a == '1) return !m_mode[5];
      if (a == 48'h0100_00C2_8001) return m_mode[4];
      if (a[0]) return m_mode[1] || (m_mode[2] && hit);
      return (a == m_sta) || (m_mode[3] && hit);
   endfunction

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 0;
      if (a == 8'h08) m_mode = d[5:0];
      if (a == 8'h44) m_sta[31:0] = d;
      if (a == 8'h48) m_sta[47:32] = d[15:0];
      if (a >= 8'h10 && a < 8'h30 && a[1:0] == 0 && ((a - 8'h10) >> 2) < WORDS)
         m_tbl[(a - 8'h10) >> 2] = d;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] v);
      @(negedge clk);
      reg_addr = a;
      #1 v = reg_rdata;
   endtask

   task automatic set_bit(input logic [47:0] a);
      logic [IDXW-1:0] ix = hidx(a);
      logic [31:0] w = m_tbl[ix >> 5];
      w[ix[4:0]] = 1'b1;
      wr(8'h10 + 8'(4 * (ix >> 5)), w);
   endtask

   task automatic send(input logic [47:0] a, input string tag);
      exp_acc.push_back(model(a));
      exp_tag.push_back(tag);
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         da_valid = 1; da_first = (i == 0); da_byte = a[8*i +: 8];
      end
      @(negedge clk);
      da_valid = 0; da_first = 0;
      chk({31'b0, rx_valid}, 1, {"R4 strobe after sixth byte ", tag});
      @(negedge clk);
      chk({31'b0, rx_valid}, 0, {"R4 strobe single cycle ", tag});
   endtask

   always @(negedge clk) begin
      logic  ea;
      string et;
      if (rst_n && rx_valid) begin
         checks++;
         if (exp_acc.size() == 0) begin
            fails++;
            $display("FAIL R12 unexpected verdict actual=%0b expected=none", rx_accept);
         end else begin
            ea = exp_acc.pop_front();
            et = exp_tag.pop_front();
            if (rx_accept !== ea) begin
               fails++;
               $display("FAIL %s actual=%0b expected=%0b", et, rx_accept, ea);
            end
         end
      end
   end

   initial begin
      #(8 * 150000);
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   localparam logic [47:0] MC_A  = 48'h3322_1100_5E01;
   localparam logic [47:0] MC_B  = 48'h7766_5500_5E01;
   localparam logic [47:0] MC_C  = 48'h0102_0304_0507;
   localparam logic [47:0] UC_S  = 48'h5544_3322_1100;
   localparam logic [47:0] UC_X  = 48'hABCD_EF01_2302;
   localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
   localparam logic [47:0] PAUSE = 48'h0100_00C2_8001;

   initial begin
      logic [31:0] v;
      for (int i = 0; i < WORDS; i++) m_tbl[i] = 0;
      repeat (3) @(negedge clk);
      chk({31'b0, rx_valid}, 0, "R4 idle in reset");
      rst_n = 1;
      rd(8'h08, v);  chk(v, 0, "R1 mode reset");
      rd(8'h40, v);  chk(v, 32'h0200_0000, "R2 feature depth code");
      wr(8'h40, 32'hFFFF_FFFF);
      rd(8'h40, v);  chk(v, 32'h0200_0000, "R2 feature read-only");
      rd(8'h1C, v);  chk(v, 0, "R3 table word reset");
      wr(8'h08, 32'hFFFF_FFEA);
      rd(8'h08, v);  chk(v, 32'h2A, "R1 mode readback");
      wr(8'h08, 0);
      wr(8'h1C, 32'hCAFE_0001);
      rd(8'h1C, v);  chk(v, 32'hCAFE_0001, "R3 last word readback");
      wr(8'h24, 32'hDEAD_BEEF);
      rd(8'h24, v);  chk(v, 0, "R3 beyond depth ignored");
      wr(8'h1C, 0);

      // R8 hash multicast with one programmed bit
      wr(8'h08, 32'h04);
      set_bit(MC_A);
      send(MC_A, "R8 hashed multicast hit");
      send(MC_B, "R8 hashed multicast other index");
      send(MC_C, "R8 hashed multicast third");
      for (int i = 0; i < WORDS; i++) wr(8'h10 + 8'(4 * i), 32'hFFFF_FFFF);
      send(MC_B, "R8 all-ones table accepts");
      send(MC_C, "R8 all-ones table accepts 2");
      for (int i = 0; i < WORDS; i++) wr(8'h10 + 8'(4 * i), 0);
      send(MC_A, "R8 cleared table drops");

      // R9 / R10 unicast
      wr(8'h44, UC_S[31:0]);
      wr(8'h48, {16'h0, UC_S[47:32]});
      send(UC_S, "R9 station match");
      send(UC_X, "R9 station mismatch");
      wr(8'h08, 32'h08);
      set_bit(UC_X);
      send(UC_X, "R10 unicast hash hit");
      wr(8'h08, 32'h00);
      send(UC_X, "R10 unicast hash disabled");

      // R7 pass all multicast
      wr(8'h08, 32'h02);
      send(MC_B, "R7 pass all multicast");
      send(UC_X, "R7 unicast unaffected");

      // R6 broadcast
      wr(8'h08, 32'h00);
      send(BCAST, "R6 broadcast accepted");
      wr(8'h08, 32'h20);
      send(BCAST, "R6 broadcast off drops");
      wr(8'h08, 32'h21);
      send(BCAST, "R6 promiscuous overrides broadcast off");

      // R11 pause
      wr(8'h08, 32'h06);
      send(PAUSE, "R11 pause dropped without pass bit");
      wr(8'h08, 32'h10);
      send(PAUSE, "R11 pause accepted with pass bit");

      // R5 promiscuous
      wr(8'h08, 32'h01);
      send(UC_X, "R5 promiscuous unicast");
      send(MC_C, "R5 promiscuous multicast");

      // R12 restart and stray bytes
      wr(8'h08, 32'h00);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         da_valid = 1; da_first = (i == 0); da_byte = 8'hA5;
      end
      send(UC_S, "R12 restart on first byte");
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         da_valid = 1; da_first = 0; da_byte = 8'h11;
      end
      @(negedge clk);
      da_valid = 0;
      repeat (3) @(negedge clk);
      chk(exp_acc.size(), 0, "R12 stray bytes ignored");

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule